// File: doc/BRIEF.md
# Pending Request Table with d-left Hashing

This block tracks content requests that have been sent upstream and are still waiting for data. Each request presents a 32-bit name key, already hashed by logic upstream, and the number of the interface it arrived on. In one probe of the candidate buckets in all sub-tables, the table decides what to do with the request. A request for a name it has not seen is forwarded upstream. A request for a pending name from a new interface is merged into the existing entry. A request that repeats an interface already recorded is flagged as a likely loop. If no candidate bucket has room, the request is dropped.

A response presents a name key. If the name is pending, the table returns the bitmap of waiting interfaces, so the caller can multicast the data, and frees the entry in the same probe. Every entry is stamped with the tick count at insertion. A scanner walks one slot per clock and frees entries whose age in ticks is greater than the programmed lifetime. When a response and an expiry hit the same entry in the same cycle, the response wins and reports a hit, and the entry is freed only once.

Storage has four sub-tables of 256 buckets with four slots each. Each sub-table takes its bucket index from its own slice of the key, and the full key is kept as the tag. A new entry goes to the least-occupied candidate bucket. On a tie the lowest-numbered sub-table is used.

Top module: `pending_req_table`

## Requirements
- R1: While reset is asserted, and for two clocks after it is released, both result valids are low and `req_ready` and `rsp_ready` are low.
- R2: A request whose key matches no stored entry is stored and reported with status 0 (forward).
- R3: A request whose key matches a stored entry, from an interface not yet recorded, adds that interface's bit to the entry and is reported with status 1 (aggregated). No second entry is created.
- R4: A request whose interface bit is already set in the matching entry is reported with status 2 (loop) and leaves the entry unchanged.
- R5: A response whose key matches an entry reports hit=1 and the entry's bitmap, in which bit n stands for interface n. The entry is then removed.
- R6: A response whose key matches no entry reports hit=0 with an all-zero bitmap and changes no state.
- R7: Keys that differ only in bits 31:26 share all four candidate buckets. Sixteen such keys can be stored. A seventeenth is reported with status 3 (dropped) and is not stored. Freeing any one of the sixteen lets it be stored.
- R8: While `rsp_valid` is high, `req_ready` is low, so the response is served first and the request waits.
- R9: Each accepted request or response produces exactly one result beat, on the clock after the handshake.
- R10: An entry whose age in ticks is greater than `lifetime` is freed within one scan sweep (4096 clocks) and later responds as unsolicited. An entry whose age equals `lifetime` is kept.
- R11: Sub-table i takes its bucket index from key bits [6i+7:6i], so bits 31:26 take no part in bucket selection.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| tick | input | 1 | One-cycle pulse that advances the age clock |
| lifetime | input | 8 | Maximum age in ticks before an entry is freed |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle |
| req_key | input | 32 | Hashed name key of the request |
| req_if | input | 4 | Arrival interface number |
| req_res_valid | output | 1 | Request result beat |
| req_res_status | output | 2 | 0 forward, 1 aggregated, 2 loop, 3 dropped |
| rsp_valid | input | 1 | Response present |
| rsp_ready | output | 1 | Response accepted this cycle |
| rsp_key | input | 32 | Hashed name key of the response |
| rsp_res_valid | output | 1 | Response result beat |
| rsp_res_hit | output | 1 | Key was pending |
| rsp_res_ifset | output | 16 | Interfaces to receive the data |

## Verification
The bench covers four cases. It repeats an interface on a pending name: a design that merged blindly would report aggregation where it should report a loop. It fills all sixteen colliding slots and then adds one more key: a design with a wrong index slice or a wrong fullness test would either reject too early or overwrite a live entry. It presents a response and a request in the same cycle: a design with the wrong priority would accept the request first. It ages one entry exactly to the lifetime and another one tick past it: an off-by-one in the age comparison would free the first or keep the second.

// File: rtl/pit_pkg.sv
package pit_pkg;

  typedef enum logic [1:0] {
    ST_FORWARD   = 2'd0,
    ST_AGGREGATE = 2'd1,
    ST_LOOP      = 2'd2,
    ST_DROP      = 2'd3
  } req_status_e;

endpackage

// File: rtl/pit_bucket_index.sv
module pit_bucket_index #(
  parameter int KEY_W    = 32,
  parameter int NUM_SUB  = 4,
  parameter int BKT_W    = 8,
  parameter int IDX_STEP = 6
) (
  input  logic [KEY_W-1:0]         key,
  output logic [NUM_SUB*BKT_W-1:0] idx_flat
);

  for (genvar gs = 0; gs < NUM_SUB; gs++) begin : g_slice
    assign idx_flat[gs*BKT_W +: BKT_W] = key[gs*IDX_STEP +: BKT_W];
  end

endmodule

// File: rtl/pit_probe.sv
module pit_probe #(
  parameter int NUM_SUB = 4,
  parameter int SLOTS   = 4,
  parameter int KEY_W   = 32,
  parameter int IF_N    = 16
) (
  input  logic [KEY_W-1:0]                  key,
  input  logic [NUM_SUB*SLOTS-1:0]          cand_vld,
  input  logic [NUM_SUB*SLOTS*KEY_W-1:0]    cand_tag,
  input  logic [NUM_SUB*SLOTS*IF_N-1:0]     cand_ifs,
  output logic                              hit,
  output logic [$clog2(NUM_SUB)-1:0]        hit_sub,
  output logic [$clog2(SLOTS)-1:0]          hit_slot,
  output logic [IF_N-1:0]                   hit_ifs,
  output logic                              room,
  output logic [$clog2(NUM_SUB)-1:0]        ins_sub,
  output logic [$clog2(SLOTS)-1:0]          ins_slot
);

  localparam int SUB_W  = $clog2(NUM_SUB);
  localparam int SLOT_W = $clog2(SLOTS);
  localparam int CNT_W  = $clog2(SLOTS + 1);

  logic [CNT_W-1:0] load [NUM_SUB];
  logic [CNT_W-1:0] best_load;
  logic             slot_found;

  for (genvar gs = 0; gs < NUM_SUB; gs++) begin : g_load
    assign load[gs] = CNT_W'($countones(cand_vld[gs*SLOTS +: SLOTS]));
  end

  // tag match across every slot of every candidate bucket
  always_comb begin
    hit      = 1'b0;
    hit_sub  = '0;
    hit_slot = '0;
    hit_ifs  = '0;
    for (int s = 0; s < NUM_SUB; s++) begin
      for (int l = 0; l < SLOTS; l++) begin
        if (cand_vld[s*SLOTS+l] && (cand_tag[(s*SLOTS+l)*KEY_W +: KEY_W] == key)) begin
          hit      = 1'b1;
          hit_sub  = SUB_W'(s);
          hit_slot = SLOT_W'(l);
          hit_ifs  = cand_ifs[(s*SLOTS+l)*IF_N +: IF_N];
        end
      end
    end
  end

  // least-loaded bucket; strict compare keeps the leftmost on a tie
  always_comb begin
    room      = 1'b0;
    best_load = '0;
    ins_sub   = '0;
    for (int s = 0; s < NUM_SUB; s++) begin
      if ((load[s] < CNT_W'(SLOTS)) && (!room || (load[s] < best_load))) begin
        room      = 1'b1;
        best_load = load[s];
        ins_sub   = SUB_W'(s);
      end
    end
  end

  // lowest free slot inside the chosen bucket
  always_comb begin
    slot_found = 1'b0;
    ins_slot   = '0;
    for (int l = 0; l < SLOTS; l++) begin
      if (!slot_found && !cand_vld[int'(ins_sub)*SLOTS + l]) begin
        slot_found = 1'b1;
        ins_slot   = SLOT_W'(l);
      end
    end
  end

endmodule

// File: rtl/pit_age_scan.sv
module pit_age_scan #(
  parameter int AGE_W = 8,
  parameter int POS_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  output logic [AGE_W-1:0] now,
  output logic [POS_W-1:0] scan_pos
);

  logic [AGE_W-1:0] now_d;
  logic [POS_W-1:0] pos_d;

  always_comb begin
    now_d = now;
    if (tick) now_d = now + AGE_W'(1);
    pos_d = scan_pos + POS_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      now      <= '0;
      scan_pos <= '0;
    end else begin
      if (tick) now <= now_d;
      scan_pos <= pos_d;
    end
  end

endmodule

// File: rtl/pending_req_table.sv
module pending_req_table #(
  parameter int KEY_W    = 32,
  parameter int IF_N     = 16,
  parameter int NUM_SUB  = 4,
  parameter int BKT_W    = 8,
  parameter int SLOTS    = 4,
  parameter int AGE_W    = 8,
  parameter int IDX_STEP = 6
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     tick,
  input  logic [AGE_W-1:0]         lifetime,
  input  logic                     req_valid,
  output logic                     req_ready,
  input  logic [KEY_W-1:0]         req_key,
  input  logic [$clog2(IF_N)-1:0]  req_if,
  output logic                     req_res_valid,
  output logic [1:0]               req_res_status,
  input  logic                     rsp_valid,
  output logic                     rsp_ready,
  input  logic [KEY_W-1:0]         rsp_key,
  output logic                     rsp_res_valid,
  output logic                     rsp_res_hit,
  output logic [IF_N-1:0]          rsp_res_ifset
);
  import pit_pkg::*;

  localparam int BUCKETS = 1 << BKT_W;
  localparam int SUB_W   = $clog2(NUM_SUB);
  localparam int SLOT_W  = $clog2(SLOTS);
  localparam int POS_W   = SUB_W + BKT_W + SLOT_W;
  localparam int CAND    = NUM_SUB * SLOTS;

  // reset: asynchronous assert, synchronous release
  logic rst_meta_q, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  // storage
  logic             tbl_vld   [NUM_SUB][BUCKETS][SLOTS];
  logic [KEY_W-1:0] tbl_tag   [NUM_SUB][BUCKETS][SLOTS];
  logic [IF_N-1:0]  tbl_ifs   [NUM_SUB][BUCKETS][SLOTS];
  logic [AGE_W-1:0] tbl_stamp [NUM_SUB][BUCKETS][SLOTS];

  // operation select: response has priority
  logic             op_rsp, op_req;
  logic [KEY_W-1:0] op_key;
  logic [IF_N-1:0]  if_bit;

  assign rsp_ready = rst_sync_n;
  assign req_ready = rst_sync_n && !rsp_valid;
  assign op_rsp    = rsp_valid && rsp_ready;
  assign op_req    = req_valid && req_ready;
  assign op_key    = op_rsp ? rsp_key : req_key;
  assign if_bit    = IF_N'(1) << req_if;

  logic [NUM_SUB*BKT_W-1:0] idx_flat;

  pit_bucket_index #(
    .KEY_W(KEY_W), .NUM_SUB(NUM_SUB), .BKT_W(BKT_W), .IDX_STEP(IDX_STEP)
  ) u_index (
    .key(op_key), .idx_flat(idx_flat)
  );

  logic [CAND-1:0]       cand_vld;
  logic [CAND*KEY_W-1:0] cand_tag;
  logic [CAND*IF_N-1:0]  cand_ifs;

  for (genvar gs = 0; gs < NUM_SUB; gs++) begin : g_sub
    for (genvar gl = 0; gl < SLOTS; gl++) begin : g_slot
      assign cand_vld[gs*SLOTS+gl]                = tbl_vld[gs][idx_flat[gs*BKT_W +: BKT_W]][gl];
      assign cand_tag[(gs*SLOTS+gl)*KEY_W +: KEY_W] = tbl_tag[gs][idx_flat[gs*BKT_W +: BKT_W]][gl];
      assign cand_ifs[(gs*SLOTS+gl)*IF_N +: IF_N]   = tbl_ifs[gs][idx_flat[gs*BKT_W +: BKT_W]][gl];
    end
  end

  logic              hit, room;
  logic [SUB_W-1:0]  hit_sub, ins_sub;
  logic [SLOT_W-1:0] hit_slot, ins_slot;
  logic [IF_N-1:0]   hit_ifs;

  pit_probe #(
    .NUM_SUB(NUM_SUB), .SLOTS(SLOTS), .KEY_W(KEY_W), .IF_N(IF_N)
  ) u_probe (
    .key(op_key), .cand_vld(cand_vld), .cand_tag(cand_tag), .cand_ifs(cand_ifs),
    .hit(hit), .hit_sub(hit_sub), .hit_slot(hit_slot), .hit_ifs(hit_ifs),
    .room(room), .ins_sub(ins_sub), .ins_slot(ins_slot)
  );

  // age clock and scanner
  logic [AGE_W-1:0]  now;
  logic [POS_W-1:0]  scan_pos;
  logic [SUB_W-1:0]  scan_sub;
  logic [BKT_W-1:0]  scan_bkt;
  logic [SLOT_W-1:0] scan_slot;

  pit_age_scan #(.AGE_W(AGE_W), .POS_W(POS_W)) u_scan (
    .clk(clk), .rst_n(rst_sync_n), .tick(tick), .now(now), .scan_pos(scan_pos)
  );

  assign scan_slot = scan_pos[SLOT_W-1:0];
  assign scan_bkt  = scan_pos[SLOT_W +: BKT_W];
  assign scan_sub  = scan_pos[SLOT_W+BKT_W +: SUB_W];

  // next-state decision
  logic              set_en, upd_en, clr_en, exp_en, same_loc;
  logic [SUB_W-1:0]  wr_sub;
  logic [BKT_W-1:0]  wr_bkt;
  logic [SLOT_W-1:0] wr_slot;
  logic [IF_N-1:0]   upd_ifs;
  logic [AGE_W-1:0]  scan_age;

  logic              req_res_valid_d, rsp_res_valid_d, rsp_res_hit_d;
  req_status_e       req_status_d;
  logic [IF_N-1:0]   rsp_ifset_d;

  always_comb begin
    set_en          = 1'b0;
    upd_en          = 1'b0;
    clr_en          = 1'b0;
    wr_sub          = ins_sub;
    wr_slot         = ins_slot;
    upd_ifs         = hit_ifs | if_bit;
    req_res_valid_d = 1'b0;
    req_status_d    = ST_FORWARD;
    rsp_res_valid_d = 1'b0;
    rsp_res_hit_d   = 1'b0;
    rsp_ifset_d     = '0;
    if (op_rsp) begin
      rsp_res_valid_d = 1'b1;
      if (hit) begin
        clr_en        = 1'b1;
        wr_sub        = hit_sub;
        wr_slot       = hit_slot;
        rsp_res_hit_d = 1'b1;
        rsp_ifset_d   = hit_ifs;
      end
    end else if (op_req) begin
      req_res_valid_d = 1'b1;
      if (hit) begin
        wr_sub  = hit_sub;
        wr_slot = hit_slot;
        if (|(hit_ifs & if_bit)) begin
          req_status_d = ST_LOOP;
        end else begin
          upd_en       = 1'b1;
          req_status_d = ST_AGGREGATE;
        end
      end else if (room) begin
        set_en       = 1'b1;
        req_status_d = ST_FORWARD;
      end else begin
        req_status_d = ST_DROP;
      end
    end
  end

  assign wr_bkt   = idx_flat[wr_sub*BKT_W +: BKT_W];
  assign scan_age = now - tbl_stamp[scan_sub][scan_bkt][scan_slot];
  assign same_loc = (set_en || upd_en || clr_en) && (wr_sub == scan_sub)
                    && (wr_bkt == scan_bkt) && (wr_slot == scan_slot);
  // an operation on the scanned slot wins; a response there deletes it once
  assign exp_en   = tbl_vld[scan_sub][scan_bkt][scan_slot]
                    && (scan_age > lifetime) && !same_loc;

  // storage registers
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      for (int s = 0; s < NUM_SUB; s++)
        for (int b = 0; b < BUCKETS; b++)
          for (int l = 0; l < SLOTS; l++)
            tbl_vld[s][b][l] <= 1'b0;
    end else begin
      if (clr_en) tbl_vld[wr_sub][wr_bkt][wr_slot] <= 1'b0;
      if (set_en) tbl_vld[wr_sub][wr_bkt][wr_slot] <= 1'b1;
      if (exp_en) tbl_vld[scan_sub][scan_bkt][scan_slot] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (set_en) begin
      tbl_tag[wr_sub][wr_bkt][wr_slot]   <= op_key;
      tbl_ifs[wr_sub][wr_bkt][wr_slot]   <= if_bit;
      tbl_stamp[wr_sub][wr_bkt][wr_slot] <= now;
    end
    if (upd_en) begin
      tbl_ifs[wr_sub][wr_bkt][wr_slot]   <= upd_ifs;
    end
  end

  // result registers
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      req_res_valid  <= 1'b0;
      req_res_status <= '0;
      rsp_res_valid  <= 1'b0;
      rsp_res_hit    <= 1'b0;
      rsp_res_ifset  <= '0;
    end else begin
      req_res_valid <= req_res_valid_d;
      rsp_res_valid <= rsp_res_valid_d;
      if (req_res_valid_d) req_res_status <= req_status_d;
      if (rsp_res_valid_d) begin
        rsp_res_hit   <= rsp_res_hit_d;
        rsp_res_ifset <= rsp_ifset_d;
      end
    end
  end

endmodule

// File: rtl/pit_table_checker.sv
module pit_table_checker #(
  parameter int IF_N = 16
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_valid,
  input logic            req_ready,
  input logic            rsp_valid,
  input logic            rsp_ready,
  input logic            req_res_valid,
  input logic            rsp_res_valid,
  input logic            rsp_res_hit,
  input logic [IF_N-1:0] rsp_res_ifset
);

  // R8: a pending response blocks the request port
  a_r8_rsp_first: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !req_ready);

  // R9: one result beat per accepted request, on the next clock
  a_r9_req_beat: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> req_res_valid);

  a_r9_req_no_extra: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && req_ready) |=> !req_res_valid);

  // R9: one result beat per accepted response, on the next clock
  a_r9_rsp_beat: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_ready) |=> rsp_res_valid);

  // R5: a hit always carries at least one waiting interface
  a_r5_hit_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_res_valid && rsp_res_hit) |-> (rsp_res_ifset != '0));

  // R6: an unsolicited response reports an empty set
  a_r6_unsol_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_res_valid && !rsp_res_hit) |-> (rsp_res_ifset == '0));

endmodule

bind pending_req_table pit_table_checker #(.IF_N(IF_N)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .req_res_valid(req_res_valid),
  .rsp_res_valid(rsp_res_valid), .rsp_res_hit(rsp_res_hit), .rsp_res_ifset(rsp_res_ifset)
);

// File: tb/pending_req_table_tb_top.sv
`timescale 1ns/1ps
module pending_req_table_tb_top;

  logic        clk, rst_n, tick;
  logic [7:0]  lifetime;
  logic        req_valid, req_ready, req_res_valid;
  logic [31:0] req_key, rsp_key;
  logic [3:0]  req_if;
  logic [1:0]  req_res_status;
  logic        rsp_valid, rsp_ready, rsp_res_valid, rsp_res_hit;
  logic [15:0] rsp_res_ifset;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  pending_req_table dut_i (
    .clk(clk), .rst_n(rst_n), .tick(tick), .lifetime(lifetime),
    .req_valid(req_valid), .req_ready(req_ready), .req_key(req_key), .req_if(req_if),
    .req_res_valid(req_res_valid), .req_res_status(req_res_status),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_key(rsp_key),
    .rsp_res_valid(rsp_res_valid), .rsp_res_hit(rsp_res_hit), .rsp_res_ifset(rsp_res_ifset)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  typedef struct packed {
    logic        is_rsp;
    logic [31:0] key;
    logic [3:0]  ifn;
    logic [1:0]  st;
    logic [15:0] ifs;
  } vec_t;

  localparam logic [31:0] K1 = 32'h1234_5678;
  localparam logic [31:0] K2 = 32'h0000_00A5;
  localparam logic [31:0] K3 = 32'hFFFF_0001;
  localparam logic [31:0] K9 = 32'hDEAD_BEEF;

  localparam vec_t VECS [0:11] = '{
    '{1'b0, K1, 4'd2,  2'd0, 16'h0000},  // R2 new
    '{1'b0, K1, 4'd5,  2'd1, 16'h0000},  // R3 merge
    '{1'b0, K1, 4'd2,  2'd2, 16'h0000},  // R4 loop
    '{1'b1, K1, 4'd0,  2'd0, 16'h0024},  // R5 multicast set
    '{1'b1, K1, 4'd0,  2'd0, 16'h0000},  // R6 gone now
    '{1'b0, K2, 4'd0,  2'd0, 16'h0000},
    '{1'b0, K3, 4'd15, 2'd0, 16'h0000},
    '{1'b1, K3, 4'd0,  2'd0, 16'h8000},
    '{1'b1, K2, 4'd0,  2'd0, 16'h0001},
    '{1'b1, K9, 4'd0,  2'd0, 16'h0000},
    '{1'b0, K1, 4'd7,  2'd0, 16'h0000},
    '{1'b1, K1, 4'd0,  2'd0, 16'h0080}
  };

  function automatic logic [31:0] coll_key(input int k);
    return {6'(k), 26'h2AB_CDEF};
  endfunction

  task automatic check(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", rq, act, exp);
    end
  endtask

  task automatic do_req(input logic [31:0] key, input logic [3:0] ifn,
                        input logic [1:0] st, input string rq);
    @(negedge clk);
    req_valid = 1'b1; req_key = key; req_if = ifn;
    @(negedge clk);
    req_valid = 1'b0;
    check(req_res_valid && (req_res_status == st), rq,
          {29'd0, req_res_valid, req_res_status}, {29'd0, 1'b1, st});
  endtask

  task automatic do_rsp(input logic [31:0] key, input logic [15:0] ifs, input string rq);
    @(negedge clk);
    rsp_valid = 1'b1; rsp_key = key;
    @(negedge clk);
    rsp_valid = 1'b0;
    check(rsp_res_valid && (rsp_res_hit == (ifs != 0)) && (rsp_res_ifset == ifs), rq,
          {14'd0, rsp_res_valid, rsp_res_hit, rsp_res_ifset},
          {14'd0, 1'b1, (ifs != 0), ifs});
  endtask

  task automatic pulse_tick();
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; tick = 1'b0; lifetime = 8'd200;
    req_valid = 1'b0; req_key = '0; req_if = '0;
    rsp_valid = 1'b0; rsp_key = '0;
    repeat (3) @(negedge clk);
    // R1: quiet outputs while held in reset
    check(!req_res_valid && !rsp_res_valid && !req_ready && !rsp_ready, "R1",
          {28'd0, req_res_valid, rsp_res_valid, req_ready, rsp_ready}, 32'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(req_ready && rsp_ready && !req_res_valid && !rsp_res_valid, "R1",
          {28'd0, req_res_valid, rsp_res_valid, req_ready, rsp_ready}, 32'd3);

    // table walk: R2..R6, R9
    for (int i = 0; i < 12; i++) begin
      if (VECS[i].is_rsp)
        do_rsp(VECS[i].key, VECS[i].ifs, (VECS[i].ifs != 0) ? "R5" : "R6");
      else
        do_req(VECS[i].key, VECS[i].ifn, VECS[i].st,
               (VECS[i].st == 2'd0) ? "R2" : (VECS[i].st == 2'd1) ? "R3" : "R4");
    end

    // R7 / R11: fill all sixteen shared slots, then overflow
    for (int k = 0; k < 16; k++) do_req(coll_key(k), 4'(k), 2'd0, "R7_R11");
    do_req(coll_key(16), 4'd0, 2'd3, "R7");
    do_rsp(coll_key(16), 16'h0000, "R7");
    do_rsp(coll_key(3), 16'h0008, "R7");
    do_req(coll_key(16), 4'd9, 2'd0, "R7");

    // R8: response and request together
    do_req(32'h0BAD_F00D, 4'd3, 2'd0, "R8");
    @(negedge clk);
    rsp_valid = 1'b1; rsp_key = 32'h0BAD_F00D;
    req_valid = 1'b1; req_key = 32'h0777_7777; req_if = 4'd1;
    #1;
    check(!req_ready, "R8", {31'd0, req_ready}, 32'd0);
    @(negedge clk);
    rsp_valid = 1'b0;
    check(rsp_res_valid && rsp_res_hit && (rsp_res_ifset == 16'h0008) && !req_res_valid, "R8",
          {14'd0, rsp_res_valid, req_res_valid, rsp_res_ifset}, {14'd0, 2'b10, 16'h0008});
    @(negedge clk);
    req_valid = 1'b0;
    check(req_res_valid && (req_res_status == 2'd0), "R9",
          {29'd0, req_res_valid, req_res_status}, 32'd4);

    // R10: age equal to lifetime stays
    do_req(32'h0A5A_5A5A, 4'd11, 2'd0, "R10");
    lifetime = 8'd2;
    pulse_tick();
    pulse_tick();
    repeat (4200) @(negedge clk);
    do_rsp(32'h0A5A_5A5A, 16'h0800, "R10");

    // R10: age one past lifetime is freed
    do_req(32'h0C3C_3C3C, 4'd6, 2'd0, "R10");
    pulse_tick();
    pulse_tick();
    pulse_tick();
    repeat (4200) @(negedge clk);
    do_rsp(32'h0C3C_3C3C, 16'h0000, "R10");
    do_rsp(coll_key(0), 16'h0000, "R10");

    finish_run();
  end

endmodule